// File: doc/BRIEF.md
# Auxiliary I/O and Power-Control Register Block

This block is a bus-slave register file for the miscellaneous control corner of a workstation I/O chip. Software uses it to keep configuration, diagnostic and modem-control bytes, to drive a 16-bit front-panel LED word, to request a power-off or a full system reset, and to produce the terminal-count strobe that ends a floppy transfer. A power-fail line from the supply monitor is folded into a latched status bit. When enabled, that bit raises a level interrupt, and software acknowledges it with a write-to-clear bit.

Each access carries a register select, a byte offset and an access size. Every register accepts exactly one access size. An access with any other size is dropped: writes do nothing and reads return zero. Reads are combinational from the stored state. Writes take effect at the clock edge, and each side-effect output is a registered pulse in the cycle after the write.

The asynchronous active-low reset clears the configuration, modem, aux1 and aux2 bytes and the pulse outputs. The diagnostic byte, the LED word and the system-control word keep their contents, so software can find out after a reset that the reset was self-requested.

Top module: `auxctl_regs`

## Requirements
- R1: Register select codes are 0 configuration, 1 diagnostic, 2 modem control, 3 LED, 4 system control, 5 aux1, 6 aux2, and 7 is unused. A byte write (size code 0) to select 0, 1 or 2 stores wdata[7:0], and a byte read returns it zero-extended. The offset is ignored for byte registers.
- R2: Size codes are 0 byte, 1 half-word, 2 word and 3 reserved. Selects 0, 1, 2, 5 and 6 accept only byte accesses, select 3 only half-word and select 4 only word. Select 7 accepts nothing. A write with the wrong size changes nothing, and a read with the wrong size returns zero.
- R3: A half-word write to the LED register at offset 0 stores wdata[15:0]. A write at a nonzero offset is ignored, and a read at a nonzero offset returns zero.
- R4: A word write to system control at offset 0 with wdata bit 0 set loads the register with 0x2 and pulses sysreset_req high for exactly the next cycle. Writes without bit 0, or at nonzero offsets, change nothing. A read at a nonzero offset returns zero.
- R5: A write to aux1 stores the data with bit 1 forced to 0. If wdata bit 1 is set, tc_pulse is high for exactly the next cycle.
- R6: The block remembers the previous level of pwr_failing, which is taken as low after reset. In a cycle where the input differs from that level, aux2 bit 5 becomes (pwr_failing AND configuration bit 3).
- R7: pf_irq is high exactly when aux2 bit 5 and configuration bit 3 are both set. Changing either one moves the output in the cycle after the write.
- R8: A write to aux2 stores wdata bit 0 into bit 0. It keeps bit 5 unless wdata bit 1 is set, in which case bit 5 is cleared. All other bits, bit 1 included, read as zero.
- R9: A write to aux2 with wdata bit 0 set pulses poweroff_req high for exactly the next cycle.
- R10: Reset clears configuration, modem, aux1, aux2 and all pulse outputs. The diagnostic, LED and system-control contents are preserved.
- R11: When an aux2 write and a pwr_failing change fall in the same cycle, bit 5 takes the value that R6 gives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 3 | Register select |
| off | input | OFF_W | Byte offset within the selected register |
| size | input | 2 | Access size code |
| wr_en | input | 1 | Write request for this cycle |
| rd_en | input | 1 | Read request for this cycle |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, zero when no valid read |
| pwr_failing | input | 1 | Power-fail level from the supply monitor |
| pf_irq | output | 1 | Power-fail interrupt level |
| tc_pulse | output | 1 | One-cycle floppy terminal-count strobe |
| poweroff_req | output | 1 | One-cycle power-off request |
| sysreset_req | output | 1 | One-cycle system-reset request |

## Verification
The bench instantiates the block with its default parameters: a 32-bit data path, a 16-bit LED word and a 2-bit offset. With a 2-bit offset, offsets 1 to 3 are reachable, so the drop-at-nonzero-offset rule on the LED and system-control registers is exercised alongside the size-mismatch rule. The 32-bit path lets word writes carry junk in the upper bits, so the bench can show that only the specified bits have an effect. Random traffic also lines up aux2 writes with edges of the power-fail input, so the same-cycle priority between the two is exercised.

// File: rtl/auxctl_pkg.sv
package auxctl_pkg;

  typedef enum logic [2:0] {
    REG_CFG   = 3'd0,
    REG_DIAG  = 3'd1,
    REG_MODEM = 3'd2,
    REG_LED   = 3'd3,
    REG_SYS   = 3'd4,
    REG_AUX1  = 3'd5,
    REG_AUX2  = 3'd6,
    REG_NONE  = 3'd7
  } reg_sel_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  localparam int CFG_PFEN_BIT = 3;
  localparam int AUX1_TC_BIT  = 1;
  localparam int AUX2_OFF_BIT = 0;
  localparam int AUX2_CLR_BIT = 1;
  localparam int AUX2_PF_BIT  = 5;
  localparam int SYS_RST_BIT  = 0;
  localparam int SYS_STAT_BIT = 1;

  typedef struct packed {
    logic cfg;
    logic diag;
    logic modem;
    logic led;
    logic sys;
    logic aux1;
    logic aux2;
  } wr_strobe_t;

  // Access size each register answers to.
  function automatic acc_size_e size_for(input reg_sel_e s);
    case (s)
      REG_LED: return SZ_HALF;
      REG_SYS: return SZ_WORD;
      REG_NONE: return SZ_RSVD;
      default: return SZ_BYTE;
    endcase
  endfunction

  // Registers whose offset must be zero.
  function automatic logic needs_zero_off(input reg_sel_e s);
    return (s == REG_LED) || (s == REG_SYS);
  endfunction

  // Value stored into aux1: strobe bit never kept.
  function automatic logic [7:0] aux1_store(input logic [7:0] d);
    logic [7:0] r;
    r = d;
    r[AUX1_TC_BIT] = 1'b0;
    return r;
  endfunction

  // Value stored into aux2 from a write, before any power-fail event.
  function automatic logic [7:0] aux2_store(input logic [7:0] d, input logic pf_now);
    logic [7:0] r;
    r = '0;
    r[AUX2_OFF_BIT] = d[AUX2_OFF_BIT];
    r[AUX2_PF_BIT]  = pf_now & ~d[AUX2_CLR_BIT];
    return r;
  endfunction

  function automatic logic irq_level(input logic pf_en, input logic pf_stat);
    return pf_en & pf_stat;
  endfunction

endpackage

// File: rtl/auxctl_decode.sv
module auxctl_decode
  import auxctl_pkg::*;
#(
  parameter int OFF_W = 2
) (
  input  logic [2:0]       sel_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic [1:0]       size_i,
  input  logic             wr_i,
  input  logic             rd_i,
  output wr_strobe_t       wr_o,
  output logic             rd_hit_o
);

  reg_sel_e s;
  logic     width_ok;
  logic     off_ok;
  logic     hit;

  assign s        = reg_sel_e'(sel_i);
  assign width_ok = (s != REG_NONE) && (acc_size_e'(size_i) == size_for(s));
  assign off_ok   = !needs_zero_off(s) || (off_i == '0);
  assign hit      = width_ok && off_ok;
  assign rd_hit_o = rd_i && hit;

  always_comb begin
    wr_o = '0;
    if (wr_i && hit) begin
      case (s)
        REG_CFG:   wr_o.cfg   = 1'b1;
        REG_DIAG:  wr_o.diag  = 1'b1;
        REG_MODEM: wr_o.modem = 1'b1;
        REG_LED:   wr_o.led   = 1'b1;
        REG_SYS:   wr_o.sys   = 1'b1;
        REG_AUX1:  wr_o.aux1  = 1'b1;
        REG_AUX2:  wr_o.aux2  = 1'b1;
        default:   wr_o       = '0;
      endcase
    end
  end

  // R2: a strobe only ever fires for a write
  always_comb begin
    assert_strobe_needs_write_R2: assert (wr_i || (wr_o == '0));
  end

endmodule

// File: rtl/auxctl_store.sv
module auxctl_store
  import auxctl_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LED_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  wr_strobe_t        wr_i,
  input  logic [LED_W-1:0]  wdata_i,
  output logic [7:0]        cfg_q,
  output logic [7:0]        diag_q,
  output logic [7:0]        modem_q,
  output logic [7:0]        aux1_q,
  output logic [LED_W-1:0]  led_q,
  output logic [DATA_W-1:0] sys_q,
  output logic              tc_pulse_o,
  output logic              sysrst_o
);

  localparam logic [DATA_W-1:0] SYS_STAT_VAL = DATA_W'(1) << SYS_STAT_BIT;

  logic tc_fire;
  logic rst_fire;

  assign tc_fire  = wr_i.aux1 && wdata_i[AUX1_TC_BIT];
  assign rst_fire = wr_i.sys && wdata_i[SYS_RST_BIT];

  // Bytes and pulses cleared by reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q      <= '0;
      modem_q    <= '0;
      aux1_q     <= '0;
      tc_pulse_o <= 1'b0;
      sysrst_o   <= 1'b0;
    end else begin
      if (wr_i.cfg)   cfg_q   <= wdata_i[7:0];
      if (wr_i.modem) modem_q <= wdata_i[7:0];
      if (wr_i.aux1)  aux1_q  <= aux1_store(wdata_i[7:0]);
      tc_pulse_o <= tc_fire;
      sysrst_o   <= rst_fire;
    end
  end

  // Contents that outlive a reset.
  always_ff @(posedge clk) begin
    if (wr_i.diag) diag_q <= wdata_i[7:0];
    if (wr_i.led)  led_q  <= wdata_i;
    if (rst_fire)  sys_q  <= SYS_STAT_VAL;
  end

  assert_tc_has_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tc_pulse_o |-> $past(wr_i.aux1 && wdata_i[AUX1_TC_BIT]));

  assert_aux1_strobe_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !aux1_q[AUX1_TC_BIT]);

  assert_reset_req_status_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sysrst_o |-> (sys_q == SYS_STAT_VAL));

endmodule

// File: rtl/auxctl_pwr.sv
module auxctl_pwr
  import auxctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_aux2_i,
  input  logic [7:0] wdata_i,
  input  logic       pf_i,
  input  logic       pf_en_i,
  output logic [7:0] aux2_q,
  output logic       irq_o,
  output logic       poweroff_o
);

  logic       pf_prev;
  logic       pf_event;
  logic [7:0] aux2_nxt;

  assign pf_event = (pf_i != pf_prev);

  always_comb begin
    aux2_nxt = aux2_q;
    if (wr_aux2_i) aux2_nxt = aux2_store(wdata_i, aux2_q[AUX2_PF_BIT]);
    if (pf_event)  aux2_nxt[AUX2_PF_BIT] = pf_i & pf_en_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pf_prev    <= 1'b0;
      aux2_q     <= '0;
      poweroff_o <= 1'b0;
    end else begin
      pf_prev    <= pf_i;
      aux2_q     <= aux2_nxt;
      poweroff_o <= wr_aux2_i && wdata_i[AUX2_OFF_BIT];
    end
  end

  assign irq_o = irq_level(pf_en_i, aux2_q[AUX2_PF_BIT]);

  assert_poweroff_stored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    poweroff_o |-> aux2_q[AUX2_OFF_BIT]);

  assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_aux2_i && wdata_i[AUX2_CLR_BIT] && !pf_event) |=> !aux2_q[AUX2_PF_BIT]);

  assert_fall_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_event && !pf_i) |=> !aux2_q[AUX2_PF_BIT]);

  assert_event_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_event && pf_i && pf_en_i) |=> aux2_q[AUX2_PF_BIT]);

endmodule

// File: rtl/auxctl_regs.sv
module auxctl_regs
  import auxctl_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LED_W  = 16,
  parameter int OFF_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        sel,
  input  logic [OFF_W-1:0]  off,
  input  logic [1:0]        size,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              pwr_failing,
  output logic              pf_irq,
  output logic              tc_pulse,
  output logic              poweroff_req,
  output logic              sysreset_req
);

  wr_strobe_t        wr_stb;
  logic              rd_hit;
  logic [7:0]        cfg_q;
  logic [7:0]        diag_q;
  logic [7:0]        modem_q;
  logic [7:0]        aux1_q;
  logic [7:0]        aux2_q;
  logic [LED_W-1:0]  led_q;
  logic [DATA_W-1:0] sys_q;
  logic              unused_hi_wdata;

  assign unused_hi_wdata = ^wdata[DATA_W-1:LED_W];

  auxctl_decode #(.OFF_W(OFF_W)) u_decode (
    .sel_i    (sel),
    .off_i    (off),
    .size_i   (size),
    .wr_i     (wr_en),
    .rd_i     (rd_en),
    .wr_o     (wr_stb),
    .rd_hit_o (rd_hit)
  );

  auxctl_store #(.DATA_W(DATA_W), .LED_W(LED_W)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_i       (wr_stb),
    .wdata_i    (wdata[LED_W-1:0]),
    .cfg_q      (cfg_q),
    .diag_q     (diag_q),
    .modem_q    (modem_q),
    .aux1_q     (aux1_q),
    .led_q      (led_q),
    .sys_q      (sys_q),
    .tc_pulse_o (tc_pulse),
    .sysrst_o   (sysreset_req)
  );

  auxctl_pwr u_pwr (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_aux2_i  (wr_stb.aux2),
    .wdata_i    (wdata[7:0]),
    .pf_i       (pwr_failing),
    .pf_en_i    (cfg_q[CFG_PFEN_BIT]),
    .aux2_q     (aux2_q),
    .irq_o      (pf_irq),
    .poweroff_o (poweroff_req)
  );

  always_comb begin
    rdata = '0;
    if (rd_hit) begin
      case (reg_sel_e'(sel))
        REG_CFG:   rdata = DATA_W'(cfg_q);
        REG_DIAG:  rdata = DATA_W'(diag_q);
        REG_MODEM: rdata = DATA_W'(modem_q);
        REG_LED:   rdata = DATA_W'(led_q);
        REG_SYS:   rdata = sys_q;
        REG_AUX1:  rdata = DATA_W'(aux1_q);
        REG_AUX2:  rdata = DATA_W'(aux2_q);
        default:   rdata = '0;
      endcase
    end
  end

  assert_dropped_read_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rd_hit) |-> (rdata == '0));

  assert_irq_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pf_irq |-> cfg_q[CFG_PFEN_BIT]);

endmodule

// File: tb/sim_auxctl_regs.sv
module sim_auxctl_regs;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  sel = '0;
  logic [1:0]  off = '0;
  logic [1:0]  size = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        pwr_failing = 1'b0;
  logic        pf_irq, tc_pulse, poweroff_req, sysreset_req;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Reference state
  logic [7:0]  m_cfg = 0, m_diag = 0, m_modem = 0, m_aux1 = 0, m_aux2 = 0;
  logic [15:0] m_led = 0;
  logic [31:0] m_sys = 0;
  logic        m_pfq = 0, m_tc = 0, m_off = 0, m_rst = 0;
  bit          k_diag = 0, k_led = 0, k_sys = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  auxctl_regs u0 (
    .clk(clk), .rst_n(rst_n), .sel(sel), .off(off), .size(size),
    .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata),
    .pwr_failing(pwr_failing), .pf_irq(pf_irq), .tc_pulse(tc_pulse),
    .poweroff_req(poweroff_req), .sysreset_req(sysreset_req)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit access_ok(input logic [2:0] s, input logic [1:0] o, input logic [1:0] z);
    if (s == 3'd7) return 0;
    if (s == 3'd3) return (z == 2'd1) && (o == 0);
    if (s == 3'd4) return (z == 2'd2) && (o == 0);
    return z == 2'd0;
  endfunction

  function automatic string read_tag();
    if (!access_ok(sel, off, size)) return "R2";
    case (sel)
      3'd3: return "R3";
      3'd4: return "R4";
      3'd5: return "R5";
      3'd6: return "R8";
      default: return "R1";
    endcase
  endfunction

  // Advance the model over one clock edge, then compare at the falling edge.
  task automatic step();
    logic [7:0] old_cfg;
    logic [7:0] n_aux2;
    bit w;
    bit known;
    logic [31:0] exp_rd;
    @(posedge clk);
    if (!rst_n) begin
      m_cfg = 0; m_modem = 0; m_aux1 = 0; m_aux2 = 0;
      m_pfq = 0; m_tc = 0; m_off = 0; m_rst = 0;
    end else begin
      old_cfg = m_cfg;
      n_aux2 = m_aux2;
      m_tc = 0; m_off = 0; m_rst = 0;
      w = wr_en && access_ok(sel, off, size);
      if (w) begin
        case (sel)
          3'd0: m_cfg = wdata[7:0];
          3'd1: begin m_diag = wdata[7:0]; k_diag = 1; end
          3'd2: m_modem = wdata[7:0];
          3'd3: begin m_led = wdata[15:0]; k_led = 1; end
          3'd4: if (wdata[0]) begin m_sys = 32'h2; k_sys = 1; m_rst = 1; end
          3'd5: begin m_aux1 = wdata[7:0] & 8'hFD; m_tc = wdata[1]; end
          3'd6: begin
            n_aux2 = {2'b00, (m_aux2[5] & ~wdata[1]), 4'b0000, wdata[0]};
            m_off = wdata[0];
          end
          default: ;
        endcase
      end
      if (pwr_failing != m_pfq) n_aux2[5] = pwr_failing & old_cfg[3];
      m_pfq = pwr_failing;
      m_aux2 = n_aux2;
    end
    @(negedge clk);
    chk("R7", {31'b0, pf_irq}, {31'b0, m_aux2[5] & m_cfg[3]});
    chk("R5", {31'b0, tc_pulse}, {31'b0, m_tc});
    chk("R9", {31'b0, poweroff_req}, {31'b0, m_off});
    chk("R4", {31'b0, sysreset_req}, {31'b0, m_rst});
    known = 1;
    exp_rd = 0;
    if (rd_en && access_ok(sel, off, size)) begin
      case (sel)
        3'd0: exp_rd = {24'b0, m_cfg};
        3'd1: begin exp_rd = {24'b0, m_diag}; known = k_diag; end
        3'd2: exp_rd = {24'b0, m_modem};
        3'd3: begin exp_rd = {16'b0, m_led}; known = k_led; end
        3'd4: begin exp_rd = m_sys; known = k_sys; end
        3'd5: exp_rd = {24'b0, m_aux1};
        3'd6: exp_rd = {24'b0, m_aux2};
        default: exp_rd = 0;
      endcase
    end
    if (known && rst_n) chk(read_tag(), rdata, exp_rd);
  endtask

  task automatic wr(input logic [2:0] s, input logic [1:0] o, input logic [1:0] z, input logic [31:0] d);
    sel = s; off = o; size = z; wdata = d; wr_en = 1; rd_en = 0;
    step();
    wr_en = 0;
  endtask

  task automatic rd_check(input logic [2:0] s, input logic [1:0] o, input logic [1:0] z,
                          input logic [31:0] exp, input string tag);
    sel = s; off = o; size = z; wr_en = 0; rd_en = 1;
    #1;
    chk(tag, rdata, exp);
    step();
    rd_en = 0;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog (all) actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    repeat (3) step();
    rst_n = 1;
    step();
    // R10 reset state
    rd_check(3'd0, 0, 0, 32'h0, "R10");
    rd_check(3'd2, 0, 0, 32'h0, "R10");
    rd_check(3'd5, 0, 0, 32'h0, "R10");
    rd_check(3'd6, 0, 0, 32'h0, "R10");
    chk("R10", {28'b0, pf_irq, tc_pulse, poweroff_req, sysreset_req}, 32'h0);

    // R1 byte registers
    wr(3'd0, 0, 0, 32'hFFFF_FFA5);
    wr(3'd1, 2, 0, 32'h0000_003C);
    wr(3'd2, 0, 0, 32'h0000_005A);
    rd_check(3'd0, 0, 0, 32'hA5, "R1");
    rd_check(3'd1, 0, 0, 32'h3C, "R1");
    rd_check(3'd2, 3, 0, 32'h5A, "R1");

    // R2 wrong size
    wr(3'd0, 0, 2, 32'h0000_0011);
    rd_check(3'd0, 0, 0, 32'hA5, "R2");
    rd_check(3'd0, 0, 1, 32'h0, "R2");
    wr(3'd7, 0, 0, 32'hFF);
    rd_check(3'd7, 0, 0, 32'h0, "R2");

    // R3 LED word
    wr(3'd3, 0, 1, 32'hDEAD_BEEF);
    rd_check(3'd3, 0, 1, 32'hBEEF, "R3");
    wr(3'd3, 1, 1, 32'h1234);
    rd_check(3'd3, 0, 1, 32'hBEEF, "R3");
    rd_check(3'd3, 2, 1, 32'h0, "R3");
    wr(3'd3, 0, 0, 32'h5555);
    rd_check(3'd3, 0, 1, 32'hBEEF, "R2");

    // R4 system control
    wr(3'd4, 0, 2, 32'h0000_0001);
    chk("R4", {31'b0, sysreset_req}, 32'h1);
    step();
    chk("R4", {31'b0, sysreset_req}, 32'h0);
    rd_check(3'd4, 0, 2, 32'h2, "R4");
    rd_check(3'd4, 1, 2, 32'h0, "R4");
    wr(3'd4, 2, 2, 32'h1);
    chk("R4", {31'b0, sysreset_req}, 32'h0);
    wr(3'd4, 0, 2, 32'hFFFF_FFFE);
    chk("R4", {31'b0, sysreset_req}, 32'h0);

    // R5 aux1 strobe
    wr(3'd5, 0, 0, 32'hFF);
    chk("R5", {31'b0, tc_pulse}, 32'h1);
    step();
    chk("R5", {31'b0, tc_pulse}, 32'h0);
    rd_check(3'd5, 0, 0, 32'hFD, "R5");
    wr(3'd5, 0, 0, 32'h41);
    chk("R5", {31'b0, tc_pulse}, 32'h0);
    rd_check(3'd5, 0, 0, 32'h41, "R5");

    // R6 / R7 power fail
    wr(3'd0, 0, 0, 32'h08);
    pwr_failing = 1; step();
    rd_check(3'd6, 0, 0, 32'h20, "R6");
    chk("R7", {31'b0, pf_irq}, 32'h1);
    wr(3'd0, 0, 0, 32'h00);
    chk("R7", {31'b0, pf_irq}, 32'h0);
    rd_check(3'd6, 0, 0, 32'h20, "R6");
    wr(3'd0, 0, 0, 32'h08);
    chk("R7", {31'b0, pf_irq}, 32'h1);
    pwr_failing = 0; step();
    rd_check(3'd6, 0, 0, 32'h00, "R6");
    wr(3'd0, 0, 0, 32'h00);
    pwr_failing = 1; step();
    rd_check(3'd6, 0, 0, 32'h00, "R6");

    // R8 / R9 aux2 writes
    wr(3'd0, 0, 0, 32'h08);
    pwr_failing = 0; step();
    pwr_failing = 1; step();
    wr(3'd6, 0, 0, 32'h01);
    chk("R9", {31'b0, poweroff_req}, 32'h1);
    rd_check(3'd6, 0, 0, 32'h21, "R8");
    wr(3'd6, 0, 0, 32'h02);
    chk("R9", {31'b0, poweroff_req}, 32'h0);
    rd_check(3'd6, 0, 0, 32'h00, "R8");
    chk("R7", {31'b0, pf_irq}, 32'h0);
    wr(3'd6, 0, 0, 32'hFC);
    rd_check(3'd6, 0, 0, 32'h00, "R8");
    wr(3'd6, 0, 0, 32'h03);
    chk("R9", {31'b0, poweroff_req}, 32'h1);
    rd_check(3'd6, 0, 0, 32'h01, "R9");

    // R11 same-cycle event and clear
    pwr_failing = 0; step();
    pwr_failing = 1;
    wr(3'd6, 0, 0, 32'h02);
    rd_check(3'd6, 0, 0, 32'h20, "R11");
    chk("R11", {31'b0, pf_irq}, 32'h1);

    // R10 retention across reset
    wr(3'd1, 0, 0, 32'h3C);
    rst_n = 0; step(); step();
    rst_n = 1; step();
    rd_check(3'd1, 0, 0, 32'h3C, "R10");
    rd_check(3'd4, 0, 2, 32'h2, "R10");
    rd_check(3'd3, 0, 1, 32'hBEEF, "R10");
    rd_check(3'd0, 0, 0, 32'h0, "R10");
    rd_check(3'd6, 0, 0, 32'h0, "R10");

    // Mixed traffic against the model
    for (int i = 0; i < 4000; i++) begin
      sel   = 3'($urandom_range(0, 7));
      size  = 2'($urandom_range(0, 3));
      off   = ($urandom_range(0, 3) == 0) ? 2'($urandom_range(1, 3)) : 2'd0;
      wdata = $urandom;
      wr_en = ($urandom_range(0, 2) == 0);
      rd_en = ($urandom_range(0, 1) == 0);
      if ($urandom_range(0, 7) == 0) pwr_failing = ~pwr_failing;
      rst_n = ($urandom_range(0, 299) != 0);
      step();
    end
    rst_n = 1; wr_en = 0; rd_en = 0;
    step();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule